// File: doc/BRIEF.md
# Four-Phase Interlocked Bus Handshake

This block joins a bus master controller to a slave responder over a fully interlocked four-phase request/acknowledge exchange. It supports both read and write transfers. A local requester pulses `start` with a direction, an address and, for writes, a data word. The master puts address, direction and write data on the bus lines. It waits a fixed number of decode cycles so that the target can recognise its address, and only then raises the request line.

The slave holds a small word store. When it sees the request, it either stores the write word or places the addressed word on its read-data lines, and then raises acknowledge. The master answers the acknowledge by dropping the request. For a read, the master captures the word at that moment. The slave then drops acknowledge and stops driving read data. Once the master sees acknowledge low, it signals completion with a single-cycle `done` pulse. Each side receives the other side's handshake line through a two-flop synchronizer, so the two halves could sit in unrelated timing domains.

The bus lines stay visible at the top-level ports, so the edge ordering can be observed from outside the block.

Top module: `hs4_link`

## Requirements
- R1: A `start` sampled while idle loads address, direction and write data onto the bus lines at that clock edge. Those lines stay unchanged until acknowledge has fallen. `bus_req` goes high exactly DECODE_CYC clock edges after the accepting edge.
- R2: On a write (`cmd_write`=1), acknowledge rises only while request is high. The word is stored at the addressed location, and a later read of that location returns it.
- R3: Request falls only while acknowledge is high. Acknowledge falls only while request is low. Request never rises while acknowledge is still high.
- R4: On a read (`cmd_write`=0), `bus_rdata` carries the addressed word whenever acknowledge is high and is all zeros whenever acknowledge is low. The master presents the word on `rd_data` and holds it there until the next read completes.
- R5: `done` is high for exactly one cycle per transfer, after acknowledge has fallen. `busy` is high from the accepting edge through the `done` cycle.
- R6: A `start` asserted while `busy` is high is ignored. The bus lines, the stored words and the transfer in progress are all unaffected.
- R7: After reset every stored word reads as zero, and `busy`, `done`, `bus_req`, `bus_ack`, `bus_rdata` and `rd_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer (sampled when idle) |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | ADDR_W | Target word address |
| cmd_wdata | input | DATA_W | Write word |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Word returned by the last read |
| bus_req | output | 1 | Bus request line (master to slave) |
| bus_ack | output | 1 | Bus acknowledge line (slave to master) |
| bus_addr | output | ADDR_W | Bus address lines |
| bus_write | output | 1 | Bus direction line |
| bus_rdata | output | DATA_W | Slave read-data lines |

## Verification
The bench builds the block with ADDR_W=3, DATA_W=8 and DECODE_CYC=3. The whole eight-word store can therefore be swept: every location is read at its reset value, written with an arithmetic pattern, read back, overwritten with the complement and read back again. A decode delay of three cycles makes the request-raise latency clearly distinct from the synchronizer latency, so the bench can measure it on every transfer. The short transfers also leave room to inject a stray `start` in the middle of a transfer and to check every request and acknowledge edge on every cycle.

// File: rtl/hs4_pkg.sv
package hs4_pkg;

    typedef enum logic [2:0] {
        M_IDLE  = 3'd0,
        M_SETUP = 3'd1,
        M_REQ   = 3'd2,
        M_REL   = 3'd3,
        M_DONE  = 3'd4
    } mst_state_e;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_ACK  = 1'b1
    } slv_state_e;

endpackage

// File: rtl/hs4_sync.sv
module hs4_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d = {pipe_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/hs4_master.sv
module hs4_master
    import hs4_pkg::*;
#(
    parameter int ADDR_W     = 3,
    parameter int DATA_W     = 8,
    parameter int DECODE_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cmd_write,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    input  logic              ack_s,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              req,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_write,
    output logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              done
);
    localparam int CNT_W = (DECODE_CYC < 2) ? 1 : $clog2(DECODE_CYC);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DECODE_CYC - 1);

    typedef struct packed {
        mst_state_e        state;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic              write;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
    } mst_regs_t;

    mst_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        case (r_q.state)
            M_IDLE: begin
                if (start) begin
                    r_d.state = M_SETUP;
                    r_d.cnt   = '0;
                    r_d.addr  = cmd_addr;
                    r_d.write = cmd_write;
                    r_d.wdata = cmd_wdata;
                end
            end
            M_SETUP: begin
                if (r_q.cnt == CNT_LAST) r_d.state = M_REQ;
                else                     r_d.cnt   = r_q.cnt + 1'b1;
            end
            M_REQ: begin
                if (ack_s) begin
                    if (!r_q.write) r_d.rdata = bus_rdata;
                    r_d.state = M_REL;
                end
            end
            M_REL: begin
                if (!ack_s) r_d.state = M_DONE;
            end
            M_DONE:  r_d.state = M_IDLE;
            default: r_d.state = M_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: M_IDLE, default: '0};
        else        r_q <= r_d;
    end

    assign req       = (r_q.state == M_REQ);
    assign busy      = (r_q.state != M_IDLE);
    assign done      = (r_q.state == M_DONE);
    assign bus_addr  = r_q.addr;
    assign bus_write = r_q.write;
    assign bus_wdata = r_q.wdata;
    assign rd_data   = r_q.rdata;

    // R5: completion strobe never lasts two cycles
    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R1: request only ever follows the decode wait
    a_r1_req_after_setup: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req) |-> $past(r_q.state) == M_SETUP);
endmodule

// File: rtl/hs4_slave.sv
module hs4_slave
    import hs4_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_s,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_write,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              ack,
    output logic [DATA_W-1:0] bus_rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    typedef struct packed {
        slv_state_e                    state;
        logic [DATA_W-1:0]             rdata;
        logic [DEPTH-1:0][DATA_W-1:0]  mem;
    } slv_regs_t;

    slv_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        case (r_q.state)
            S_IDLE: begin
                if (req_s) begin
                    if (bus_write) r_d.mem[bus_addr] = bus_wdata;
                    else           r_d.rdata         = r_q.mem[bus_addr];
                    r_d.state = S_ACK;
                end
            end
            S_ACK: begin
                if (!req_s) begin
                    r_d.state = S_IDLE;
                    r_d.rdata = '0;
                end
            end
            default: r_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: S_IDLE, default: '0};
        else        r_q <= r_d;
    end

    assign ack       = (r_q.state == S_ACK);
    assign bus_rdata = r_q.rdata;

    // R4: read lines are quiet whenever acknowledge is low
    a_r4_rdata_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !ack |-> bus_rdata == '0);
endmodule

// File: rtl/hs4_link.sv
module hs4_link #(
    parameter int ADDR_W     = 3,
    parameter int DATA_W     = 8,
    parameter int DECODE_CYC = 2,
    parameter int SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cmd_write,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              bus_req,
    output logic              bus_ack,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_write,
    output logic [DATA_W-1:0] bus_rdata
);
    logic              req_s, ack_s;
    logic [DATA_W-1:0] bus_wdata;

    hs4_master #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DECODE_CYC(DECODE_CYC)) u_mst (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .ack_s(ack_s),
        .bus_rdata(bus_rdata), .req(bus_req), .bus_addr(bus_addr),
        .bus_write(bus_write), .bus_wdata(bus_wdata), .rd_data(rd_data),
        .busy(busy), .done(done)
    );

    hs4_sync #(.STAGES(SYNC_DEPTH)) u_req_sync (
        .clk(clk), .rst_n(rst_n), .d(bus_req), .q(req_s)
    );

    hs4_sync #(.STAGES(SYNC_DEPTH)) u_ack_sync (
        .clk(clk), .rst_n(rst_n), .d(bus_ack), .q(ack_s)
    );

    hs4_slave #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_slv (
        .clk(clk), .rst_n(rst_n), .req_s(req_s), .bus_addr(bus_addr),
        .bus_write(bus_write), .bus_wdata(bus_wdata), .ack(bus_ack),
        .bus_rdata(bus_rdata)
    );

    // R2: slave answers only a live request
    a_r2_ack_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_ack) |-> bus_req);
    // R3: request released only after acknowledge seen
    a_r3_req_fall_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_req) |-> bus_ack);
    // R3: acknowledge released only after request gone
    a_r3_ack_fall_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_ack) |-> !bus_req);
    // R3: no new request while acknowledge still up
    a_r3_no_req_over_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> !bus_ack);
    // R1: bus lines frozen across the handshake
    a_r1_lines_stable: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_req || bus_ack) && $past(bus_req || bus_ack)) |->
            ($stable(bus_addr) && $stable(bus_write)));
endmodule

// File: tb/hs4_link_tb.sv
module hs4_link_tb;
    localparam int AW  = 3;
    localparam int DW  = 8;
    localparam int DEC = 3;

    logic          clk = 0;
    logic          rst_n = 0;
    logic          start = 0;
    logic          cmd_write = 0;
    logic [AW-1:0] cmd_addr = '0;
    logic [DW-1:0] cmd_wdata = '0;
    logic          busy, done, bus_req, bus_ack, bus_write;
    logic [DW-1:0] rd_data, bus_rdata;
    logic [AW-1:0] bus_addr;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    hs4_link #(.ADDR_W(AW), .DATA_W(DW), .DECODE_CYC(DEC), .SYNC_DEPTH(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .busy(busy), .done(done),
        .rd_data(rd_data), .bus_req(bus_req), .bus_ack(bus_ack),
        .bus_addr(bus_addr), .bus_write(bus_write), .bus_rdata(bus_rdata)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Edge-ordering monitor, sampled at the falling edge
    logic          p_req = 0, p_ack = 0;
    logic [AW-1:0] p_addr = '0;
    logic          p_wr = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (bus_ack && !p_ack) chk(bus_req, "R2 ack rise with req", bus_req, 1);
            if (!bus_req && p_req) chk(bus_ack, "R3 req fall with ack", bus_ack, 1);
            if (!bus_ack && p_ack) chk(!bus_req, "R3 ack fall req low", bus_req, 0);
            if (bus_req && !p_req) chk(!bus_ack, "R3 req rise ack low", bus_ack, 0);
            if ((bus_req || bus_ack) && (p_req || p_ack))
                chk(bus_addr == p_addr && bus_write == p_wr, "R1 lines stable",
                    bus_addr, p_addr);
            if (!bus_ack) chk(bus_rdata == 0, "R4 rdata quiet", bus_rdata, 0);
        end
        p_req = bus_req; p_ack = bus_ack; p_addr = bus_addr; p_wr = bus_write;
    end

    task automatic txn(input bit wr, input int a, input int wd, input int exp_rd,
                       input bit stray);
        int k;
        @(negedge clk);
        start = 1; cmd_write = wr; cmd_addr = AW'(a); cmd_wdata = DW'(wd);
        @(negedge clk);
        start = 0; cmd_wdata = ~DW'(wd); cmd_addr = ~AW'(a); cmd_write = !wr;
        chk(busy == 1, "R5 busy after accept", busy, 1);
        chk(bus_addr == AW'(a) && bus_write == wr, "R1 lines loaded", bus_addr, a);
        k = 0;
        while (!bus_req) begin
            @(negedge clk); k++;
        end
        chk(k == DEC, "R1 decode delay", k, DEC);
        if (stray) begin
            start = 1; cmd_write = 1; cmd_addr = AW'(a + 1); cmd_wdata = 8'hEE;
            @(negedge clk);
            start = 0;
            chk(bus_addr == AW'(a) && bus_write == wr, "R6 stray start ignored",
                bus_addr, a);
        end
        while (!bus_ack) @(negedge clk);
        if (!wr) chk(bus_rdata == DW'(exp_rd), "R4 bus read data", bus_rdata, exp_rd);
        while (!done) @(negedge clk);
        chk(!bus_ack && !bus_req, "R5 done after ack low", bus_ack, 0);
        if (!wr) chk(rd_data == DW'(exp_rd), "R4 rd_data", rd_data, exp_rd);
        @(negedge clk);
        chk(done == 0 && busy == 0, "R5 single done", done, 0);
    endtask

    function automatic int pat(input int a);
        return (a * 29 + 7) & 8'hFF;
    endfunction

    initial begin
        #10000000;
        failures++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(!busy && !done && !bus_req && !bus_ack && bus_rdata == 0 && rd_data == 0,
            "R7 reset outputs", {busy, done, bus_req, bus_ack}, 0);
        for (int a = 0; a < (1 << AW); a++) txn(0, a, 0, 0, 0);          // R7 store zero
        for (int a = 0; a < (1 << AW); a++) txn(1, a, pat(a), 0, 0);     // R2 writes
        for (int a = 0; a < (1 << AW); a++) txn(0, a, 0, pat(a), 0);     // R2/R4 read back
        for (int a = 0; a < (1 << AW); a++) txn(1, a, (~pat(a)) & 8'hFF, 0, (a % 2) == 0);
        for (int a = 0; a < (1 << AW); a++) txn(0, a, 0, (~pat(a)) & 8'hFF, 0); // R6 no corruption
        // R4: rd_data held over a write
        txn(1, 2, 8'h5A, 0, 0);
        chk(rd_data == DW'((~pat(7)) & 8'hFF), "R4 rd_data held", rd_data, (~pat(7)) & 8'hFF);
        txn(0, 2, 0, 8'h5A, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule